// File: doc/BRIEF.md
# Floating-Point Compare to Condition Code

This block compares two IEEE-754 operands and stores the boolean outcome in one of eight condition-code bits of a 32-bit floating-point status register. A precision input selects how the operands are read. They are either a pair of single-precision values in the low 32 bits of each operand bus, or a pair of double-precision values that use the full 64 bits.

Each compare operation carries three controls. The first is the ordered predicate to evaluate. The second is the result to store when the pair is unordered, meaning at least one operand is a NaN. The third is a trap control; when it is set, a quiet NaN operand is treated as an invalid operation and the condition code is left alone. A signaling NaN operand always raises the invalid-operation cause bit and the sticky invalid flag.

Software reads the status register at all times. Software writes the whole register through a write port.

Top module: `fcmp_cc_unit`

## Requirements
- R1: After a synchronous reset the status register output reads 0.
- R2: A write strobe loads the full 32-bit write data at the next clock edge. If a write and a compare strobe arrive in the same cycle, the write wins and the compare is dropped.
- R3: When neither the write strobe nor the compare strobe is asserted, the status register keeps its value.
- R4: When neither operand is a NaN, the stored result is the selected predicate applied to the operands. The predicate encodings are: 0 = equal, 1 = less-than, 2 = less-or-equal, 3 = always false. Positive and negative zero compare equal, and infinities order at the extremes.
- R5: Precision 0 reads single-precision operands from bits 31:0 of each operand bus and ignores bits 63:32. Precision 1 reads double-precision operands from all 64 bits.
- R6: When either operand is a NaN (all-ones exponent, non-zero mantissa), the stored result is the unordered-value input and the predicate has no effect. This does not apply to the trap case in R9.
- R7: Condition-code index 0 writes status bit 23, and index k in the range 1 to 7 writes status bit 24+k. A compare changes no other bit, except the invalid bits of R8 and R9.
- R8: A signaling NaN operand (mantissa top bit 0) sets status bit 16 (invalid cause) and bit 6 (sticky invalid flag) whatever the trap control says. Unless R9 applies, the condition code is still written.
- R9: When the trap control is set and either operand is a quiet NaN (mantissa top bit 1), bits 16 and 6 are set and the selected condition-code bit is not written.
- R10: A compare with no invalid condition leaves bits 16 and 6 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_vld_i | input | 1 | Compare strobe |
| dbl_i | input | 1 | Precision: 0 single, 1 double |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| pred_i | input | 2 | Ordered predicate select |
| unord_val_i | input | 1 | Result stored when the operands are unordered |
| qnan_trap_i | input | 1 | Treat quiet NaNs as invalid and suppress the write |
| cc_idx_i | input | 3 | Condition-code index |
| csr_wr_i | input | 1 | Status register write strobe |
| csr_wdata_i | input | 32 | Status register write data |
| csr_o | output | 32 | Status register contents |

## Verification
The hardest case to reach is a stored bit that is wrong only because it was written when it should have been left alone, or left alone when it should have been written. This happens with trap suppression and with preservation of the bits the compare does not select. A cleared register cannot show either fault. The bench therefore reloads the register with a dense pattern before each group of operand pairs and rotates the condition-code index with every operation. It then sweeps every pair from a set of special values (both zeros, denormals, both infinities, quiet and signaling NaNs) across all predicates, unordered values, trap settings and both precisions. Expected results come from real-number comparison in the bench.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  typedef enum logic [1:0] {
    PRED_EQ   = 2'd0,
    PRED_LT   = 2'd1,
    PRED_LE   = 2'd2,
    PRED_NONE = 2'd3
  } pred_e;

  typedef struct packed {
    logic sign;
    logic is_zero;
    logic is_nan;
    logic is_qnan;
    logic is_snan;
  } fcls_t;
endpackage

// File: rtl/fcc_classify.sv
module fcc_classify
  import fcc_pkg::*;
#(
  parameter int DW     = 64,
  parameter int SW     = 32,
  parameter int D_EXPW = 11,
  parameter int S_EXPW = 8
) (
  input  logic          dbl_i,
  input  logic [DW-1:0] op_i,
  output fcls_t         cls_o,
  output logic [DW-2:0] mag_o
);
  localparam int D_MANW = DW - 1 - D_EXPW;
  localparam int S_MANW = SW - 1 - S_EXPW;

  logic exp_ones, man_nz, man_top;

  always_comb begin
    mag_o = '0;
    if (dbl_i) begin
      cls_o.sign = op_i[DW-1];
      exp_ones   = &op_i[DW-2 -: D_EXPW];
      man_nz     = |op_i[D_MANW-1:0];
      man_top    = op_i[D_MANW-1];
      mag_o      = op_i[DW-2:0];
    end else begin
      cls_o.sign      = op_i[SW-1];
      exp_ones        = &op_i[SW-2 -: S_EXPW];
      man_nz          = |op_i[S_MANW-1:0];
      man_top         = op_i[S_MANW-1];
      mag_o[SW-2:0]   = op_i[SW-2:0];
    end
    cls_o.is_zero = (mag_o == '0);
    cls_o.is_nan  = exp_ones & man_nz;
    cls_o.is_qnan = cls_o.is_nan & man_top;
    cls_o.is_snan = cls_o.is_nan & ~man_top;
  end
endmodule

// File: rtl/fcc_order.sv
module fcc_order
  import fcc_pkg::*;
#(
  parameter int MW = 63
) (
  input  fcls_t         cls_a_i,
  input  fcls_t         cls_b_i,
  input  logic [MW-1:0] mag_a_i,
  input  logic [MW-1:0] mag_b_i,
  input  pred_e         pred_i,
  output logic          res_o
);
  logic both_zero, is_eq, is_lt;

  always_comb begin
    both_zero = cls_a_i.is_zero & cls_b_i.is_zero;
    is_eq     = both_zero | ((cls_a_i.sign == cls_b_i.sign) && (mag_a_i == mag_b_i));
    if (both_zero)
      is_lt = 1'b0;
    else if (cls_a_i.sign != cls_b_i.sign)
      is_lt = cls_a_i.sign;
    else if (cls_a_i.sign)
      is_lt = mag_a_i > mag_b_i;
    else
      is_lt = mag_a_i < mag_b_i;

    case (pred_i)
      PRED_EQ: res_o = is_eq;
      PRED_LT: res_o = is_lt;
      PRED_LE: res_o = is_lt | is_eq;
      default: res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fcmp_cc_unit.sv
module fcmp_cc_unit
  import fcc_pkg::*;
#(
  parameter int DW        = 64,
  parameter int SW        = 32,
  parameter int D_EXPW    = 11,
  parameter int S_EXPW    = 8,
  parameter int CSR_W     = 32,
  parameter int CCW       = 3,
  parameter int CC0_POS   = 23,
  parameter int CCHI_BASE = 24,
  parameter int INV_CAUSE = 16,
  parameter int INV_FLAG  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_vld_i,
  input  logic             dbl_i,
  input  logic [DW-1:0]    opa_i,
  input  logic [DW-1:0]    opb_i,
  input  logic [1:0]       pred_i,
  input  logic             unord_val_i,
  input  logic             qnan_trap_i,
  input  logic [CCW-1:0]   cc_idx_i,
  input  logic             csr_wr_i,
  input  logic [CSR_W-1:0] csr_wdata_i,
  output logic [CSR_W-1:0] csr_o
);
  localparam int PW = $clog2(CSR_W);
  localparam int MW = DW - 1;

  logic [DW-1:0] ops [2];
  fcls_t         cls [2];
  logic [MW-1:0] mag [2];

  assign ops[0] = opa_i;
  assign ops[1] = opb_i;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fcc_classify #(.DW(DW), .SW(SW), .D_EXPW(D_EXPW), .S_EXPW(S_EXPW)) u_cls (
      .dbl_i (dbl_i),
      .op_i  (ops[g]),
      .cls_o (cls[g]),
      .mag_o (mag[g])
    );
  end

  logic ord_res;
  fcc_order #(.MW(MW)) u_ord (
    .cls_a_i (cls[0]),
    .cls_b_i (cls[1]),
    .mag_a_i (mag[0]),
    .mag_b_i (mag[1]),
    .pred_i  (pred_e'(pred_i)),
    .res_o   (ord_res)
  );

  logic             nan_any, qnan_any, snan_any, trap_hit, inv, res;
  logic [PW-1:0]    cc_pos;
  logic [CSR_W-1:0] csr_q, csr_nxt;

  always_comb begin
    nan_any  = cls[0].is_nan  | cls[1].is_nan;
    qnan_any = cls[0].is_qnan | cls[1].is_qnan;
    snan_any = cls[0].is_snan | cls[1].is_snan;
    trap_hit = qnan_trap_i & qnan_any;
    inv      = snan_any | trap_hit;
    res      = nan_any ? unord_val_i : ord_res;
    cc_pos   = (cc_idx_i == '0) ? PW'(CC0_POS) : PW'(CCHI_BASE + int'(cc_idx_i));
    csr_nxt  = csr_q;
    if (inv) begin
      csr_nxt[INV_CAUSE] = 1'b1;
      csr_nxt[INV_FLAG]  = 1'b1;
    end
    if (!trap_hit) csr_nxt[cc_pos] = res;
  end

  always_ff @(posedge clk) begin
    if (rst)            csr_q <= '0;
    else if (csr_wr_i)  csr_q <= csr_wdata_i;
    else if (cmp_vld_i) csr_q <= csr_nxt;
  end

  assign csr_o = csr_q;

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!cmp_vld_i && !csr_wr_i) |=> $stable(csr_o));

  a_r2_write: assert property (@(posedge clk) disable iff (rst)
    csr_wr_i |=> (csr_o == $past(csr_wdata_i)));

  a_r8_snan_invalid: assert property (@(posedge clk) disable iff (rst)
    (cmp_vld_i && !csr_wr_i && snan_any) |=> (csr_o[INV_CAUSE] && csr_o[INV_FLAG]));

  a_r9_trap_keeps_cc: assert property (@(posedge clk) disable iff (rst)
    (cmp_vld_i && !csr_wr_i && trap_hit) |=> (csr_o[$past(cc_pos)] == $past(csr_o[cc_pos])));

  a_r6_unordered: assert property (@(posedge clk) disable iff (rst)
    (cmp_vld_i && !csr_wr_i && nan_any && !trap_hit) |=> (csr_o[$past(cc_pos)] == $past(unord_val_i)));

  a_r10_clean_keeps_inv: assert property (@(posedge clk) disable iff (rst)
    (cmp_vld_i && !csr_wr_i && !nan_any) |=>
      (csr_o[INV_CAUSE] == $past(csr_o[INV_CAUSE]) && csr_o[INV_FLAG] == $past(csr_o[INV_FLAG])));
endmodule

// File: tb/fcmp_cc_unit_tb.sv
`timescale 1ns/1ps
module fcmp_cc_unit_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        cmp_vld_i = 0, dbl_i = 0, unord_val_i = 0, qnan_trap_i = 0, csr_wr_i = 0;
  logic [63:0] opa_i = '0, opb_i = '0;
  logic [1:0]  pred_i = '0;
  logic [2:0]  cc_idx_i = '0;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] csr_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_csr;

  always #2 clk = ~clk;

  fcmp_cc_unit u_dut (.*);

  localparam int NV = 11; // 0..8 numeric, 9 quiet NaN, 10 signaling NaN

  function automatic logic [63:0] enc(int i, bit dbl);
    logic [63:0] s [NV] = '{64'h0, 64'h8000_0000, 64'h3F80_0000, 64'hBF80_0000, 64'h4000_0000,
                            64'hC020_0000, 64'h7F80_0000, 64'hFF80_0000, 64'h1,
                            64'h7FC0_0000, 64'h7F80_0001};
    logic [63:0] d [NV] = '{64'h0, 64'h8000_0000_0000_0000, 64'h3FF0_0000_0000_0000,
                            64'hBFF0_0000_0000_0000, 64'h4000_0000_0000_0000,
                            64'hC004_0000_0000_0000, 64'h7FF0_0000_0000_0000,
                            64'hFFF0_0000_0000_0000, 64'h1,
                            64'hFFF8_0000_0000_0000, 64'h7FF0_0000_0000_0001};
    return dbl ? d[i] : {32'hDEAD_BEEF, s[i][31:0]};
  endfunction

  function automatic real rval(int i, bit dbl);
    real inf = $bitstoreal(64'h7FF0_0000_0000_0000);
    case (i)
      0: return 0.0;
      1: return -0.0;
      2: return 1.0;
      3: return -1.0;
      4: return 2.0;
      5: return -2.5;
      6: return inf;
      7: return -inf;
      default: return dbl ? $bitstoreal(64'h1) : 2.0 ** (-149);
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic csr_write(logic [31:0] v);
    @(negedge clk);
    csr_wr_i = 1; csr_wdata_i = v;
    @(negedge clk);
    csr_wr_i = 0;
    exp_csr = v;
    check("R2 write", csr_o, exp_csr);
  endtask

  task automatic do_cmp(bit dbl, int ia, int ib, int pr, bit un, bit trap, int cc);
    bit  nan, qn, sn, r, trap_hit;
    real a, b;
    int  pos;
    @(negedge clk);
    cmp_vld_i = 1; dbl_i = dbl; opa_i = enc(ia, dbl); opb_i = enc(ib, dbl);
    pred_i = 2'(pr); unord_val_i = un; qnan_trap_i = trap; cc_idx_i = 3'(cc);
    @(negedge clk);
    cmp_vld_i = 0;
    nan = (ia >= 9) || (ib >= 9);
    qn  = (ia == 9) || (ib == 9);
    sn  = (ia == 10) || (ib == 10);
    a = rval(ia, dbl); b = rval(ib, dbl);
    case (pr)
      0: r = (a == b);
      1: r = (a < b);
      2: r = (a <= b);
      default: r = 0;
    endcase
    if (nan) r = un;
    trap_hit = trap && qn;
    pos = (cc == 0) ? 23 : 24 + cc;
    if (sn || trap_hit) begin exp_csr[16] = 1; exp_csr[6] = 1; end
    if (!trap_hit) exp_csr[pos] = r;
    check(nan ? (trap_hit ? "R9 trap" : (sn ? "R8 snan" : "R6 unordered"))
              : (dbl ? "R4 R7 R10 compare dbl" : "R4 R5 R7 R10 compare sgl"),
          csr_o, exp_csr);
  endtask

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int k = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 reset", csr_o, 32'h0);

    // R2: write has priority over a simultaneous compare
    csr_write(32'h0000_0000);
    @(negedge clk);
    csr_wr_i = 1; csr_wdata_i = 32'h1234_5678; cmp_vld_i = 1; dbl_i = 1;
    opa_i = enc(10, 1); opb_i = enc(0, 1); cc_idx_i = 0; unord_val_i = 1;
    @(negedge clk);
    csr_wr_i = 0; cmp_vld_i = 0;
    exp_csr = 32'h1234_5678;
    check("R2 priority", csr_o, exp_csr);

    for (int dbl = 0; dbl < 2; dbl++)
      for (int trap = 0; trap < 2; trap++)
        for (int un = 0; un < 2; un++)
          for (int pr = 0; pr < 4; pr++)
            for (int ia = 0; ia < NV; ia++) begin
              k++;
              csr_write(((32'hA5C3_96E1 ^ (32'(k) * 32'h9E37_79B9)) | (un ? 32'hFE80_0000 : 32'h0))
                        & ~32'h0001_0040);
              for (int ib = 0; ib < NV; ib++)
                do_cmp(bit'(dbl), ia, ib, pr, bit'(un), bit'(trap), (ia + ib + pr) % 8);
              // R3: idle cycle with junk on the inputs
              @(negedge clk);
              opa_i = enc(10, 1); opb_i = enc(9, 1); cc_idx_i = 3'(k);
              @(negedge clk);
              check("R3 hold", csr_o, exp_csr);
            end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule